// File: doc/BRIEF.md
# Edge-Latched Masked Interrupt Controller

This block is the interrupt front end of a bus-attached digital I/O card. It watches eight external lines. Each line has its own synchronizer, edge detector and sticky event latch. A per-line bit picks which edge is captured.

Captured events are held in the latches before the mask is applied. An event that arrives while its line is masked is kept. It becomes pending once software opens the mask, unless software has cleared it first. Pending events raise one bus interrupt request at a programmed level, but only while the global enable is set. When an acknowledge cycle arrives for that level, the block returns a programmed vector byte. Any other acknowledge is passed on down the daisy chain.

Software reaches the block through a small register port with a combinational read path. The latches do not respond to the block reset. Software must empty them through the clear register before it enables interrupts.

Top module: `edge_irq_ctrl`

## Requirements
- R1: A line whose edge-select bit (register 0x6, bit i for line i) is 1 latches an event on a low-to-high transition. With the mask open, the event shows in the pending register on the third rising clock edge after the input change.
- R2: A line whose edge-select bit is 0 latches only on a high-to-low transition. A rising transition on that line has no effect on the pending register.
- R3: The pending register (0x2, read only) equals latch AND mask (0x3, 1 = pass). An event latched while its mask bit is 0 is held. It reads as pending in the same cycle that its mask bit is written to 1.
- R4: Register map on a 4-bit address: 0x1 control (bit 0 = global enable), 0x2 pending, 0x3 mask, 0x4 clear (write only, reads 0), 0x5 vector, 0x6 edge select, 0x7 request level (bits 2:0). Every other address reads 0.
- R5: A write to 0x4 clears each latch whose written bit is 1 and leaves every other latch unchanged.
- R6: If an edge is detected on a line in the same cycle that a clear write targets that line, the latch ends up set.
- R7: `bus_irq` is 1 exactly when the enable bit is 1, the pending register is non-zero and the level is non-zero. `irq_level` always equals the level register.
- R8: When `iack_in` is 1 and `iack_level` equals the level register while `bus_irq` is 1, the block drives `vec_valid` = 1, puts the vector register on `vec_data` and drives `iack_out` = 0. In every other case `iack_out` follows `iack_in`, `vec_valid` is 0 and `vec_data` is 0.
- R9: A low `rst_n` at a clock edge sets control, mask, vector, edge select and level to 0. It leaves the event latches unchanged.
- R10: An input pulse that lasts two clock periods is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the configuration registers |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq_in | input | 8 | External interrupt lines |
| bus_irq | output | 1 | Bus interrupt request |
| irq_level | output | 3 | Programmed request level |
| iack_in | input | 1 | Acknowledge from upstream of the daisy chain |
| iack_level | input | 3 | Level being acknowledged |
| iack_out | output | 1 | Acknowledge passed downstream |
| vec_valid | output | 1 | The block is answering the acknowledge |
| vec_data | output | 8 | Vector byte returned on acknowledge |

## Verification
The bench drives rising and falling transitions on lines set for each edge polarity. This shows whether the edge-select bit is honoured in both directions. A two-cycle pulse on a masked line, followed by opening the mask, tells holding ahead of the mask apart from gating before the latch. It also checks the minimum pulse width. A clear write timed to land in the same cycle as a detected edge separates edge-wins from clear-wins. A mid-run reset followed by reopening the mask shows whether the latches survive reset. Acknowledges at matching and non-matching levels tell answering apart from passing down the chain.

// File: rtl/eirq_pkg.sv
// Shared constants for the edge-latched interrupt controller.
// Assumes a 4-bit register address space and one data byte per register.
package eirq_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'h1;
    localparam logic [ADDR_W-1:0] A_PEND  = 4'h2;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'h3;
    localparam logic [ADDR_W-1:0] A_CLEAR = 4'h4;
    localparam logic [ADDR_W-1:0] A_VECT  = 4'h5;
    localparam logic [ADDR_W-1:0] A_EDGE  = 4'h6;
    localparam logic [ADDR_W-1:0] A_LEVEL = 4'h7;
endpackage

// File: rtl/eirq_edge_det.sv
// Double-flop synchronizer and per-line edge detector.
// Bit i of rise_sel picks a rising (1) or falling (0) capture edge.
// Assumes the inputs are asynchronous. The flops have no reset: they
// settle after two clocks, so a reset never creates a false edge.
module eirq_edge_det #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic [N-1:0] din,
    input  logic [N-1:0] rise_sel,
    output logic [N-1:0] ev
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    // Synchronize the inputs and keep the previous synchronized sample.
    always_ff @(posedge clk) begin
        meta_q <= din;
        sync_q <= meta_q;
        prev_q <= sync_q;
    end

    // Per-line edge selection.
    for (genvar i = 0; i < N; i++) begin : g_edge
        assign ev[i] = rise_sel[i] ? (sync_q[i] & ~prev_q[i])
                                   : (~sync_q[i] & prev_q[i]);
    end
endmodule

// File: rtl/eirq_latch_bank.sv
// Sticky event latches, one per line, held ahead of the mask.
// A new event beats a clear in the same cycle. On purpose there is no
// reset: software empties the latches through the clear register.
module eirq_latch_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] latch_q
);
    // Clear the selected bits, then set the bits that saw an event.
    always_ff @(posedge clk) begin
        latch_q <= (latch_q & ~clr) | ev;
    end
endmodule

// File: rtl/eirq_regs.sv
// Configuration registers, clear-pulse decode and the read multiplexer.
// Assumes one write per cycle. Reads are combinational from the address.
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int N     = 8,
    parameter int LVL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      pending,
    output logic [N-1:0]      rdata,
    output logic              en_q,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      vect_q,
    output logic [N-1:0]      rise_q,
    output logic [LVL_W-1:0]  level_q,
    output logic [N-1:0]      clr
);
    // Write the configuration registers; a synchronous reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mask_q  <= '0;
            vect_q  <= '0;
            rise_q  <= '0;
            level_q <= '0;
        end else if (wr) begin
            case (addr)
                A_CTRL:  en_q    <= wdata[0];
                A_MASK:  mask_q  <= wdata;
                A_VECT:  vect_q  <= wdata;
                A_EDGE:  rise_q  <= wdata;
                A_LEVEL: level_q <= wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    // Per-bit clear strobe from a write to the clear register.
    assign clr = (rst_n && wr && addr == A_CLEAR) ? wdata : '0;

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[0] = en_q;
            A_PEND:  rdata = pending;
            A_MASK:  rdata = mask_q;
            A_VECT:  rdata = vect_q;
            A_EDGE:  rdata = rise_q;
            A_LEVEL: rdata[LVL_W-1:0] = level_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/eirq_ack.sv
// Bus request and acknowledge daisy-chain logic.
// Answers only an acknowledge for its own level while it is requesting.
// Otherwise it passes the acknowledge downstream. Purely combinational.
module eirq_ack #(
    parameter int N     = 8,
    parameter int LVL_W = 3
) (
    input  logic             en,
    input  logic [N-1:0]     pending,
    input  logic [LVL_W-1:0] level,
    input  logic [N-1:0]     vect,
    input  logic             iack_in,
    input  logic [LVL_W-1:0] iack_level,
    output logic             bus_irq,
    output logic             iack_out,
    output logic             vec_valid,
    output logic [N-1:0]     vec_data
);
    logic claim;

    // Request while enabled, something is pending and a level is set.
    assign bus_irq = en && (|pending) && (level != '0);

    // Claim a matching acknowledge; otherwise pass it along.
    assign claim     = iack_in && bus_irq && (iack_level == level);
    assign vec_valid = claim;
    assign vec_data  = claim ? vect : '0;
    assign iack_out  = iack_in && !claim;
endmodule

// File: rtl/edge_irq_ctrl.sv
// Top of the edge-latched masked interrupt controller: edge detect,
// sticky latches ahead of the mask, register file, request and acknowledge.
// Assumes reg_wdata is as wide as the number of lines.
module edge_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int N     = 8,
    parameter int LVL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    input  logic [N-1:0]      irq_in,
    output logic              bus_irq,
    output logic [LVL_W-1:0]  irq_level,
    input  logic              iack_in,
    input  logic [LVL_W-1:0]  iack_level,
    output logic              iack_out,
    output logic              vec_valid,
    output logic [N-1:0]      vec_data
);
    logic [N-1:0]     edge_ev, latch_q, clr_bits, pend;
    logic [N-1:0]     mask_q, vect_q, rise_q;
    logic [LVL_W-1:0] level_q;
    logic             en_q;

    eirq_edge_det #(.N(N)) u_edge (
        .clk(clk), .din(irq_in), .rise_sel(rise_q), .ev(edge_ev)
    );

    eirq_latch_bank #(.N(N)) u_latch (
        .clk(clk), .ev(edge_ev), .clr(clr_bits), .latch_q(latch_q)
    );

    // Mask applied after the latches.
    assign pend = latch_q & mask_q;

    eirq_regs #(.N(N), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .pending(pend), .rdata(reg_rdata),
        .en_q(en_q), .mask_q(mask_q), .vect_q(vect_q), .rise_q(rise_q),
        .level_q(level_q), .clr(clr_bits)
    );

    eirq_ack #(.N(N), .LVL_W(LVL_W)) u_ack (
        .en(en_q), .pending(pend), .level(level_q), .vect(vect_q),
        .iack_in(iack_in), .iack_level(iack_level), .bus_irq(bus_irq),
        .iack_out(iack_out), .vec_valid(vec_valid), .vec_data(vec_data)
    );

    assign irq_level = level_q;
endmodule

// File: rtl/eirq_chk.sv
// Assertion checker bound into edge_irq_ctrl. It observes the latch,
// edge and clear nets and the request and acknowledge ports.
module eirq_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] ev,
    input logic [N-1:0] latch,
    input logic [N-1:0] clr,
    input logic [N-1:0] pending,
    input logic         en,
    input logic         bus_irq,
    input logic         iack_in,
    input logic         iack_out,
    input logic         vec_valid
);
    // R5
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((latch & $past(clr) & ~$past(ev)) == '0));

    // R6
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((latch & $past(ev)) == $past(ev)));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) == 1'b0 |=> ((latch & ~$past(latch)) == '0));

    // R7
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_irq |-> (en && pending != '0));

    // R8
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && iack_out));

    // R8
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_in |-> (!iack_out && !vec_valid));
endmodule

bind edge_irq_ctrl eirq_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev(edge_ev), .latch(latch_q),
    .clr(clr_bits), .pending(pend), .en(en_q), .bus_irq(bus_irq),
    .iack_in(iack_in), .iack_out(iack_out), .vec_valid(vec_valid)
);

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = 4'h2;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       bus_irq;
    logic [2:0] irq_level;
    logic       iack_in = 1'b0;
    logic [2:0] iack_level = 3'd0;
    logic       iack_out, vec_valid;
    logic [7:0] vec_data;

    int checks = 0;
    int failures = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .bus_irq(bus_irq), .irq_level(irq_level), .iack_in(iack_in),
        .iack_level(iack_level), .iack_out(iack_out),
        .vec_valid(vec_valid), .vec_data(vec_data)
    );

    // Behavioural reference state.
    logic [7:0] hist[$] = '{8'h00, 8'h00, 8'h00};
    logic [7:0] m_latch = 8'h00;
    logic       m_en = 1'b0;
    logic [7:0] m_mask = 8'h00, m_vect = 8'h00, m_rise = 8'h00;
    logic [2:0] m_lvl = 3'd0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [3:0] a);
        case (a)
            4'h1: return {7'b0, m_en};
            4'h2: return m_latch & m_mask;
            4'h3: return m_mask;
            4'h5: return m_vect;
            4'h6: return m_rise;
            4'h7: return {5'b0, m_lvl};
            default: return 8'h00;
        endcase
    endfunction

    // Advance the model at each edge, then compare shortly after.
    always @(posedge clk) begin
        logic [7:0] s2, pv, ev, clr;
        logic m_req, m_claim;
        s2 = hist[1];
        pv = hist[2];
        ev = 8'h00;
        for (int i = 0; i < 8; i++)
            ev[i] = m_rise[i] ? (s2[i] && !pv[i]) : (!s2[i] && pv[i]);
        clr = (rst_n && reg_wr && reg_addr == 4'h4) ? reg_wdata : 8'h00;
        m_latch = (m_latch & ~clr) | ev;
        hist.push_front(irq_in);
        void'(hist.pop_back());
        if (!rst_n) begin
            m_en = 0; m_mask = 0; m_vect = 0; m_rise = 0; m_lvl = 0;
        end else if (reg_wr) begin
            case (reg_addr)
                4'h1: m_en = reg_wdata[0];
                4'h3: m_mask = reg_wdata;
                4'h5: m_vect = reg_wdata;
                4'h6: m_rise = reg_wdata;
                4'h7: m_lvl = reg_wdata[2:0];
                default: ;
            endcase
        end
        #2;
        if (model_on) begin
            m_req = m_en && ((m_latch & m_mask) != 0) && m_lvl != 0;
            m_claim = iack_in && m_req && iack_level == m_lvl;
            chk("R4 rdata", reg_rdata, m_read(reg_addr));
            chk("R7 bus_irq", bus_irq, m_req);
            chk("R7 irq_level", irq_level, m_lvl);
            chk("R8 vec_valid", vec_valid, m_claim);
            chk("R8 vec_data", vec_data, m_claim ? m_vect : 8'h00);
            chk("R8 iack_out", iack_out, iack_in && !m_claim);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'h2;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        reg_addr = 4'h2;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        // R9: configuration registers come out of reset at zero
        rd(4'h1, 8'h00, "R9 ctrl after reset");
        rd(4'h3, 8'h00, "R9 mask after reset");
        rd(4'h6, 8'h00, "R9 edge after reset");
        rd(4'h7, 8'h00, "R9 level after reset");
        rd(4'h9, 8'h00, "R4 unused address");
        wr(4'h4, 8'hFF);
        model_on = 1'b1;
        wr(4'h6, 8'h0F);
        wr(4'h3, 8'hFF);
        wr(4'h7, 8'h03);
        wr(4'h5, 8'hA5);
        wr(4'h1, 8'h01);
        rd(4'h5, 8'hA5, "R4 vector readback");
        rd(4'h4, 8'h00, "R4 clear reads zero");
        // R1: rising edge on line 0
        @(negedge clk); irq_in = 8'h01;
        wait_clk(4);
        rd(4'h2, 8'h01, "R1 rising captured");
        chk("R7 request raised", bus_irq, 1'b1);
        // R2: rising edge on falling-mode line 7 is ignored
        @(negedge clk); irq_in = 8'h81;
        wait_clk(4);
        rd(4'h2, 8'h01, "R2 rise ignored");
        @(negedge clk); irq_in = 8'h01;
        wait_clk(4);
        rd(4'h2, 8'h81, "R2 falling captured");
        // R8: acknowledge at own level and at another level
        @(negedge clk); iack_in = 1'b1; iack_level = 3'd3;
        #1;
        chk("R8 claim vec", vec_data, 8'hA5);
        chk("R8 claim no pass", iack_out, 1'b0);
        @(negedge clk); iack_level = 3'd2;
        #1;
        chk("R8 other level passes", iack_out, 1'b1);
        @(negedge clk); iack_in = 1'b0;
        // R5: selective clear
        wr(4'h4, 8'h80);
        rd(4'h2, 8'h01, "R5 selective clear");
        wr(4'h4, 8'hFF);
        rd(4'h2, 8'h00, "R5 clear all");
        chk("R7 request drops", bus_irq, 1'b0);
        // R3 and R10: two-cycle pulse on masked line 1, then unmask
        wr(4'h3, 8'hFD);
        @(negedge clk); irq_in = 8'h03;
        wait_clk(2);
        irq_in = 8'h01;
        wait_clk(4);
        rd(4'h2, 8'h00, "R3 masked event hidden");
        wr(4'h3, 8'hFF);
        rd(4'h2, 8'h02, "R3 R10 held event appears");
        // R6: edge on line 2 meets a clear of line 2 in the same cycle
        @(negedge clk); irq_in = 8'h05;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'h2;
        rd(4'h2, 8'h06, "R6 edge beats clear");
        // R9: reset leaves the latches intact
        @(negedge clk); rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        rd(4'h2, 8'h00, "R9 mask reset");
        rd(4'h1, 8'h00, "R9 ctrl reset");
        wr(4'h3, 8'hFF);
        rd(4'h2, 8'h06, "R9 latches kept");
        chk("R9 no request without enable", bus_irq, 1'b0);
        wait_clk(2);
        done = 1'b1;
        finish_run();
    end
endmodule